// File: doc/BRIEF.md
# Serial Slave Memory Access Bridge

This block lets an external host reach a byte-wide on-chip memory through a four-wire serial slave port. A transaction lasts as long as the active-low select is held low. The host first clocks in one command byte. It then sends a 16-bit start address, most significant bit first. Any data bytes follow, each also most significant bit first.

The top two bits of the command choose the action:

- **Read:** a burst read that streams memory bytes back to the host.
- **Write:** a burst write that stores the host's bytes.
- **Message:** a command-only message that is parked in two registers for the local CPU.

Two exact command values suppress the CPU interrupt. Every other accepted frame raises it once, when select is released.

All serial lines are brought into the system clock domain through flop synchronizers. The system clock must run at least eight times faster than the serial clock. Input bits are taken on serial clock rising edges, and output bits change on falling edges. The memory side is a synchronous port with one cycle of read latency. Read data for each byte is fetched before its first bit slot.

Top module: `spi_mem_bridge`

## Requirements
- R1: A frame is an 8-bit command followed by a 16-bit address, both sent most significant bit first and taken on serial clock rising edges while select is low.
- R2: A command with bits [7:6] = 11 reads memory starting at the frame address, one byte per 8 serial clocks, with the address rising by one per byte. Byte k appears on the serial output in bit slots 24+8k to 31+8k, most significant bit first, changing on falling edges. The memory has one cycle of read latency.
- R3: A command with bits [7:6] = 10 writes each complete data byte received from bit slot 24 onward to consecutive addresses, starting at the frame address. The address wraps from 0xFFFF to 0x0000. Each write is a one-cycle write-enable pulse.
- R4: Command 0xC0 (read) and command 0x80 (write) raise no interrupt. Every other read or write command raises one interrupt after select rises, including frames with no data bytes.
- R5: A command with bit 7 = 0 touches no memory and ignores its data bytes. It copies the command and address into the message registers and raises the interrupt.
- R6: The serial output enable is low during the command and address slots, during whole write and message frames, and while select is high. It is high during the data slots of a read frame.
- R7: A frame whose select rises before the 24th address bit performs no memory access, raises no interrupt and leaves the message registers unchanged.
- R8: After reset, the output enable, memory strobes, interrupt and message registers are all zero.
- R9: The interrupt is a pulse exactly one system clock long.
- R10: Write enable and read enable are never high together. Write enable is high only in write frames, and read enable only in read frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low frame select from host |
| spi_sck | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (pad is high impedance when low) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 8 | Memory read data, valid one cycle after mem_re |
| cpu_irq | output | 1 | One-cycle interrupt pulse to the CPU |
| msg_cmd | output | 8 | Last message command |
| msg_addr | output | ADDR_W | Last message address |

## Verification
The hardest situations to reach are the ones where select rises at an awkward moment. One is a rise in the middle of the address. Another is a frame that ends right after the address, with no data, so that the interrupt decision rests only on the header. The bench's frame task takes an explicit bit count, which lets it cut frames off at 12 and 16 bits and also send zero-byte read and write frames. A burst starting at 0xFFFF covers the address wrap.

Read-back checks compare the bytes the host samples against a behavioural memory model. That memory model is filled through earlier write frames.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_MSG   = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_READ  = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e kind;
    logic irq;
  } cmd_info_t;

  // Top bit clear: message. Bit 6 picks read or write.
  // Low six bits all zero mean the interrupt is suppressed.
  function automatic cmd_info_t decode_cmd(input logic [BYTE_W-1:0] c);
    cmd_info_t r;
    if (!c[7]) begin
      r.kind = ACC_MSG;
      r.irq  = 1'b1;
    end else if (c[6]) begin
      r.kind = ACC_READ;
      r.irq  = (c[5:0] != 6'd0);
    end else begin
      r.kind = ACC_WRITE;
      r.irq  = (c[5:0] != 6'd0);
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/spi_bridge_rx.sv
module spi_bridge_rx import spi_bridge_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n_s,
  input  logic                       sck_s,
  input  logic                       mosi_s,
  output logic                       frame_start,
  output logic                       frame_end,
  output logic                       sck_fall,
  output logic [BYTE_W-1:0]          cmd_byte,
  output logic                       hdr_done,
  output logic [ADDR_W-1:0]          hdr_addr,
  output logic                       data_done,
  output logic [BYTE_W-1:0]          data_byte,
  output logic [$clog2(BYTE_W)-1:0]  bit_idx,
  output logic                       in_data
);

  localparam int HDR_BYTES = 1 + ADDR_W / BYTE_W;
  localparam int CNT_W     = $clog2(HDR_BYTES + 1);
  localparam int IDX_W     = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] DATA_CNT = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(BYTE_W - 1);

  logic              sck_q, cs_q;
  logic [CNT_W-1:0]  byte_cnt;
  logic [ADDR_W-1:0] shreg, next_bits;
  logic              rise, fall, cs_fall, cs_rise;

  assign rise      = sck_s & ~sck_q & ~cs_n_s;
  assign fall      = ~sck_s & sck_q & ~cs_n_s;
  assign cs_fall   = ~cs_n_s & cs_q;
  assign cs_rise   = cs_n_s & ~cs_q;
  assign next_bits = {shreg[ADDR_W-2:0], mosi_s};
  assign in_data   = (byte_cnt == DATA_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q       <= 1'b0;
      cs_q        <= 1'b1;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      sck_fall    <= 1'b0;
      hdr_done    <= 1'b0;
      data_done   <= 1'b0;
      cmd_byte    <= '0;
      hdr_addr    <= '0;
      data_byte   <= '0;
      shreg       <= '0;
      bit_idx     <= '0;
      byte_cnt    <= '0;
    end else begin
      sck_q       <= sck_s;
      cs_q        <= cs_n_s;
      frame_start <= cs_fall;
      frame_end   <= cs_rise;
      sck_fall    <= fall;
      hdr_done    <= 1'b0;
      data_done   <= 1'b0;
      if (cs_fall || cs_rise) begin
        bit_idx  <= '0;
        byte_cnt <= '0;
      end else if (rise) begin
        shreg   <= next_bits;
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx == LAST_BIT) begin
          if (byte_cnt == '0) cmd_byte <= next_bits[BYTE_W-1:0];
          if (byte_cnt == LAST_HDR) begin
            hdr_done <= 1'b1;
            hdr_addr <= next_bits;
          end
          if (byte_cnt == DATA_CNT) begin
            data_done <= 1'b1;
            data_byte <= next_bits[BYTE_W-1:0];
          end else begin
            byte_cnt <= byte_cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_bridge_port.sv
module spi_bridge_port import spi_bridge_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  acc_e                       kind,
  input  logic                       frame_start,
  input  logic                       frame_end,
  input  logic                       sck_fall,
  input  logic                       hdr_done,
  input  logic [ADDR_W-1:0]          hdr_addr,
  input  logic                       data_done,
  input  logic [BYTE_W-1:0]          data_byte,
  input  logic [$clog2(BYTE_W)-1:0]  bit_idx,
  input  logic                       in_data,
  input  logic [BYTE_W-1:0]          mem_rdata,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [BYTE_W-1:0]          mem_wdata,
  output logic                       mem_we,
  output logic                       mem_re,
  output logic                       miso,
  output logic                       miso_oe
);

  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(BYTE_W - 1);

  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] tx_byte;
  logic              re_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      tx_byte   <= '0;
      re_d      <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      miso      <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      re_d   <= mem_re;
      if (re_d) tx_byte <= mem_rdata;

      if (hdr_done) begin
        if (kind == ACC_READ) begin
          mem_re   <= 1'b1;
          mem_addr <= hdr_addr;
          ptr      <= hdr_addr + 1'b1;
        end else begin
          ptr <= hdr_addr;
        end
      end else if (data_done) begin
        if (kind == ACC_WRITE) begin
          mem_we    <= 1'b1;
          mem_addr  <= ptr;
          mem_wdata <= data_byte;
          ptr       <= ptr + 1'b1;
        end else if (kind == ACC_READ) begin
          mem_re   <= 1'b1;
          mem_addr <= ptr;
          ptr      <= ptr + 1'b1;
        end
      end

      if (frame_start || frame_end) begin
        miso_oe <= 1'b0;
        miso    <= 1'b0;
      end else if (sck_fall && in_data && kind == ACC_READ) begin
        miso_oe <= 1'b1;
        miso    <= tx_byte[TOP_BIT - bit_idx];
      end
    end
  end

endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge import spi_bridge_pkg::*; #(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              cpu_irq,
  output logic [BYTE_W-1:0] msg_cmd,
  output logic [ADDR_W-1:0] msg_addr
);

  localparam int IDX_W = $clog2(BYTE_W);

  logic [2:0]        sync_out;
  logic              cs_n_s, sck_s, mosi_s;
  logic              frame_start, frame_end, sck_fall;
  logic              hdr_done, data_done, in_data;
  logic [BYTE_W-1:0] cmd_byte, data_byte;
  logic [ADDR_W-1:0] hdr_addr;
  logic [IDX_W-1:0]  bit_idx;
  cmd_info_t         cur_info;
  acc_e              acc_kind;
  logic              hdr_seen;

  spi_bridge_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b001)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({spi_sck, spi_mosi, spi_cs_n}),
    .dout(sync_out)
  );

  assign {sck_s, mosi_s, cs_n_s} = sync_out;

  spi_bridge_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst(rst),
    .cs_n_s(cs_n_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .frame_start(frame_start), .frame_end(frame_end), .sck_fall(sck_fall),
    .cmd_byte(cmd_byte), .hdr_done(hdr_done), .hdr_addr(hdr_addr),
    .data_done(data_done), .data_byte(data_byte),
    .bit_idx(bit_idx), .in_data(in_data)
  );

  assign cur_info = decode_cmd(cmd_byte);
  assign acc_kind = cur_info.kind;

  spi_bridge_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .kind(acc_kind),
    .frame_start(frame_start), .frame_end(frame_end), .sck_fall(sck_fall),
    .hdr_done(hdr_done), .hdr_addr(hdr_addr),
    .data_done(data_done), .data_byte(data_byte),
    .bit_idx(bit_idx), .in_data(in_data),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  // Interrupt and message registers
  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_seen <= 1'b0;
      cpu_irq  <= 1'b0;
      msg_cmd  <= '0;
      msg_addr <= '0;
    end else begin
      cpu_irq <= 1'b0;
      if (frame_start) begin
        hdr_seen <= 1'b0;
      end else if (frame_end) begin
        cpu_irq  <= hdr_seen & cur_info.irq;
        hdr_seen <= 1'b0;
      end else if (hdr_done) begin
        hdr_seen <= 1'b1;
        if (acc_kind == ACC_MSG) begin
          msg_cmd  <= cmd_byte;
          msg_addr <= hdr_addr;
        end
      end
    end
  end

endmodule

// File: rtl/spi_mem_bridge_chk.sv
module spi_mem_bridge_chk import spi_bridge_pkg::*; #(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_miso_oe,
  input logic mem_we,
  input logic mem_re,
  input logic cpu_irq,
  input logic hdr_seen,
  input acc_e acc_kind
);

  localparam int IDLE_LIMIT = SYNC_STAGES + 3;

  logic [7:0] cs_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cs_hi_cnt <= '0;
    else if (!spi_cs_n)        cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 8'hFF) cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_we && mem_re)); // R10
  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (rst) mem_we |-> acc_kind == ACC_WRITE); // R3
  AST_RE_IN_READ: assert property (@(posedge clk) disable iff (rst) mem_re |-> acc_kind == ACC_READ); // R2
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) cpu_irq |=> !cpu_irq); // R9
  AST_IRQ_NEEDS_HDR: assert property (@(posedge clk) disable iff (rst) $rose(cpu_irq) |-> $past(hdr_seen)); // R7
  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) (int'(cs_hi_cnt) > IDLE_LIMIT) |-> !spi_miso_oe); // R6
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst) spi_miso_oe |-> acc_kind == ACC_READ); // R6

endmodule

bind spi_mem_bridge spi_mem_bridge_chk #(
  .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .mem_we(mem_we), .mem_re(mem_re), .cpu_irq(cpu_irq),
  .hdr_seen(hdr_seen), .acc_kind(acc_kind)
);

// File: tb/spi_mem_bridge_tb.sv
module spi_mem_bridge_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, mem_we, mem_re, cpu_irq;
  logic [15:0] mem_addr, msg_addr;
  logic [7:0]  mem_wdata, msg_cmd;
  logic [7:0]  mem_rdata = 8'h00;

  spi_mem_bridge u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .cpu_irq(cpu_irq), .msg_cmd(msg_cmd), .msg_addr(msg_addr)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int irq_cnt = 0, re_cnt = 0, we_cnt = 0;
  bit re_ok = 0, prev_irq = 0, oe_bad = 0, done = 0;
  logic [7:0]  ram [int];
  logic [15:0] exp_wa [$];
  logic [7:0]  exp_wd [$];
  logic [7:0]  wbuf [$];
  logic [7:0]  rx_q [$];
  logic [15:0] pop_a;
  logic [7:0]  pop_d;

  function automatic logic [7:0] ram_rd(input logic [15:0] a);
    if (ram.exists(int'(a))) return ram[int'(a)];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural memory: one cycle read latency
  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= ram_rd(mem_addr);
  end

  // Per-cycle comparison against the expected event stream
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        we_cnt++;
        if (exp_wa.size() == 0) chk(0, "R10", "unexpected write", {16'h0, mem_addr}, 0);
        else begin
          pop_a = exp_wa.pop_front();
          pop_d = exp_wd.pop_front();
          chk(mem_addr == pop_a && mem_wdata == pop_d, "R1,R3", "write addr/data",
              {8'h0, mem_addr, mem_wdata}, {8'h0, pop_a, pop_d});
        end
      end
      if (mem_re) begin
        re_cnt++;
        if (!re_ok) chk(0, "R10", "unexpected read", {16'h0, mem_addr}, 0);
      end
      if (mem_we && mem_re) chk(0, "R10", "both strobes high", 1, 0);
      if (cpu_irq) begin
        irq_cnt++;
        if (prev_irq) chk(0, "R9", "interrupt wider than one cycle", 2, 1);
      end
      prev_irq = cpu_irq;
    end
  end

  task automatic spi_frame(input logic [7:0] cmd, input logic [15:0] addr,
                           input int nbytes, input int limit, input bit is_read);
    int total;
    logic [7:0] cur;
    total = (limit > 0) ? limit : 24 + 8 * nbytes;
    rx_q.delete();
    oe_bad = 0;
    cur = 8'h00;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      int k;
      k = (i - 24) / 8;
      if (i < 8)       mosi = cmd[7 - i];
      else if (i < 24) mosi = addr[23 - i];
      else             mosi = (k < wbuf.size()) ? wbuf[k][7 - ((i - 24) % 8)] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 24 || !is_read) begin
        if (miso_oe) oe_bad = 1;
      end else begin
        if (!miso_oe) oe_bad = 1;
        cur = {cur[6:0], miso};
        if ((i - 24) % 8 == 7) rx_q.push_back(cur);
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
    if (miso_oe) oe_bad = 1;
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [15:0] addr,
                          input int n, input int exp_irq, input logic [7:0] seed);
    int i0;
    i0 = irq_cnt;
    wbuf.delete();
    for (int k = 0; k < n; k++) begin
      wbuf.push_back(seed + 8'(k * 37));
      exp_wa.push_back(addr + 16'(k));
      exp_wd.push_back(seed + 8'(k * 37));
    end
    re_ok = 0;
    spi_frame(cmd, addr, n, 0, 0);
    chk(exp_wa.size() == 0, "R3", "writes outstanding", exp_wa.size(), 0);
    chk(irq_cnt - i0 == exp_irq, "R4", "write interrupt count", irq_cnt - i0, exp_irq);
    chk(!oe_bad, "R6", "output enable in write frame", oe_bad, 0);
  endtask

  task automatic do_read(input logic [7:0] cmd, input logic [15:0] addr,
                         input int n, input int exp_irq);
    int i0, w0;
    i0 = irq_cnt; w0 = we_cnt;
    wbuf.delete();
    re_ok = 1;
    spi_frame(cmd, addr, n, 0, 1);
    re_ok = 0;
    chk(rx_q.size() == n, "R2", "bytes received", rx_q.size(), n);
    for (int k = 0; k < n && k < rx_q.size(); k++)
      chk(rx_q[k] == ram_rd(addr + 16'(k)), "R2", "read data", rx_q[k], ram_rd(addr + 16'(k)));
    chk(irq_cnt - i0 == exp_irq, "R4", "read interrupt count", irq_cnt - i0, exp_irq);
    chk(we_cnt == w0, "R10", "write during read", we_cnt - w0, 0);
    chk(!oe_bad, "R6", "output enable in read frame", oe_bad, 0);
  endtask

  task automatic do_msg(input logic [7:0] cmd, input logic [15:0] addr, input int n);
    int i0, w0, r0;
    i0 = irq_cnt; w0 = we_cnt; r0 = re_cnt;
    wbuf.delete();
    for (int k = 0; k < n; k++) wbuf.push_back(8'hA5 ^ 8'(k));
    re_ok = 0;
    spi_frame(cmd, addr, n, 0, 0);
    chk(we_cnt == w0 && re_cnt == r0, "R5", "memory access by message",
        (we_cnt - w0) + (re_cnt - r0), 0);
    chk(msg_cmd == cmd, "R5", "message command", msg_cmd, cmd);
    chk(msg_addr == addr, "R5", "message address", msg_addr, addr);
    chk(irq_cnt - i0 == 1, "R5", "message interrupt", irq_cnt - i0, 1);
    chk(!oe_bad, "R6", "output enable in message frame", oe_bad, 0);
  endtask

  task automatic do_trunc(input logic [7:0] cmd, input logic [15:0] addr, input int bits);
    int i0, w0, r0;
    logic [7:0]  mc;
    logic [15:0] ma;
    i0 = irq_cnt; w0 = we_cnt; r0 = re_cnt; mc = msg_cmd; ma = msg_addr;
    wbuf.delete();
    re_ok = 0;
    spi_frame(cmd, addr, 0, bits, 0);
    chk(we_cnt == w0 && re_cnt == r0, "R7", "memory access in cut frame",
        (we_cnt - w0) + (re_cnt - r0), 0);
    chk(irq_cnt == i0, "R7", "interrupt in cut frame", irq_cnt - i0, 0);
    chk(msg_cmd == mc && msg_addr == ma, "R7", "message regs changed",
        {8'h0, msg_cmd, msg_addr}, {8'h0, mc, ma});
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!miso_oe && !mem_we && !mem_re && !cpu_irq, "R8", "strobes after reset",
        {miso_oe, mem_we, mem_re, cpu_irq}, 0);
    chk(msg_cmd == 0 && msg_addr == 0, "R8", "message regs after reset",
        {msg_cmd, msg_addr}, 0);

    do_write(8'h80, 16'h1234, 4, 0, 8'h11);   // quiet burst write
    do_read (8'hC0, 16'h1234, 4, 0);          // quiet burst read-back
    do_write(8'h85, 16'hFFFF, 2, 1, 8'h6C);   // wrap, interrupt
    do_read (8'hD3, 16'hFFFE, 3, 1);          // read across wrap, interrupt
    do_msg  (8'h3A, 16'hBEEF, 2);             // message with ignored data
    do_trunc(8'h81, 16'h4000, 12);            // cut inside the address
    do_trunc(8'h12, 16'h5555, 16);            // cut message
    do_write(8'h81, 16'h0100, 0, 1, 8'h00);   // header only write, interrupt
    do_read (8'hC0, 16'h0100, 0, 0);          // header only quiet read
    do_msg  (8'h00, 16'h0001, 0);             // message with zero command
    do_read (8'hFF, 16'h1235, 2, 1);          // mid-burst start

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule